// File: doc/BRIEF.md
# Per-CPU Dual-Mode Counter/Timer

This block gives one processor a private counter/timer that runs in one of two modes, picked by an external mode input. In counter mode it counts upward from zero in steps of 2^STEP_LSB. When the next step would reach a programmed limit, the count wraps to zero, a reached flag is set and the local interrupt is raised. Software acknowledges the event by reading the limit word.

In user mode the same storage becomes a 63-bit free-running count. Software reads and loads it as an upper word and a lower word. It starts and stops the count through a run bit. This mode never raises an interrupt: reaching the top of the count only sets the reached flag.

Access is through a small word-addressed 32-bit register port. A cycle with `bus_sel` high and `bus_we` low is a read. A cycle with both high is a write. `bus_rdata` is valid in the same cycle as the read. A change of the mode input takes effect on the next clock edge. In that cycle its side effects take priority over any bus write and over any tick. In counter mode a limit of zero makes the count run freely up to the highest 31-bit step value, 0x7FFFFE00.

Top module: `cpu_dual_timer`

## Requirements
- R1: After reset the interrupt is low, word 3 reads 1 (running), word 1 reads 0 and word 0 reads 0 (limit zero).
- R2: In counter mode each tick adds 2^STEP_LSB (0x200 by default) to the count. When count plus one step is at or above the limit, the count becomes 0, the reached flag is set and the interrupt goes high on that clock edge.
- R3: In counter mode a read of word 0 returns the limit and clears both the reached flag and the interrupt. A read of word 1 returns the reached flag in bit 31 and the count in bits 30:0, and the low STEP_LSB bits of that word are always zero.
- R4: In counter mode a write to word 0 stores the data masked with 0x7FFFFE00 as the limit, restarts the count at 0 and clears the interrupt. A write to word 2 stores the limit the same way and leaves the count unchanged.
- R5: In counter mode writes to word 3 have no effect: the count keeps advancing and word 3 still reads 1.
- R6: When the mode input rises, on the next edge the interrupt goes low, the running flag goes to 0 and the count is cleared. The reached flag keeps its value.
- R7: In user mode word 0 reads as {reached, count[62:32]} and word 1 reads as count[31:0]. A write to word 0 loads count[63:32] with the data masked to 31 bits. A write to word 1 loads count[31:0] with its low STEP_LSB bits forced to zero. Either write clears the reached flag.
- R8: In user mode, writing word 3 with bit 0 = 1 sets the running flag and bit 0 = 0 clears it. Word 3 reads the running flag. The count only advances on ticks while running.
- R9: In user mode a step that lands on 0x7FFFFFFFFFFFFE00 sets the reached flag and wraps the count to 0. The interrupt stays low throughout user mode.
- R10: When the mode input falls, on the next edge the running flag becomes 1 and the count is cleared. The stored limit is kept and is used again.
- R11: A read of word 2 returns 0 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Step enable, one count step per high cycle |
| user_mode | input | 1 | 1 selects user mode, 0 selects counter mode |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt to the local processor |

## Verification
On every cycle the assertions check the following:
- The interrupt stays low in user mode.
- The running flag is always set in counter mode.
- The side effects of both mode transitions occur.
- The upper count bit never gets set.
- The low bits of the count word read as zero.
- A stopped user count holds still unless it is loaded.

Only the bench's scenarios can show the arithmetic results:
- the exact tick on which the limit is hit, for a sweep of limits;
- the no-reset limit update;
- carries from the lower word into the upper word;
- the wrap at the top of the user count;
- read-to-acknowledge, and the value of the limit kept across a mode round trip.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_HI_LIM   = 2'd0,
        REG_LO_CNT   = 2'd1,
        REG_LIM_KEEP = 2'd2,
        REG_RUN      = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [2*WORD_W-1:0] count;
        logic [WORD_W-1:0]   limit;
        logic                reached;
        logic                running;
        logic                irq;
        logic                mode;
    } tmr_state_t;
endpackage

// File: rtl/cdt_step_adder.sv
`timescale 1ns/1ps
module cdt_step_adder #(
    parameter int STEP_LSB = 9,
    parameter int CNT_W    = 64
) (
    input  logic [CNT_W-1:0] cur_cnt,
    input  logic [CNT_W-1:0] term_cnt,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1) << STEP_LSB;

    logic [CNT_W-1:0] sum;

    always_comb begin
        sum     = cur_cnt + STEP;
        hit     = (sum >= term_cnt);
        nxt_cnt = hit ? '0 : sum;
    end
endmodule

// File: rtl/cdt_rd_mux.sv
`timescale 1ns/1ps
module cdt_rd_mux
    import cdt_pkg::*;
(
    input  logic                  mode,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*WORD_W-1:0]   count,
    input  logic [WORD_W-1:0]     limit,
    input  logic                  reached,
    input  logic                  running,
    output logic [WORD_W-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            REG_HI_LIM: rdata = mode ? {reached, count[2*WORD_W-2:WORD_W]} : limit;
            REG_LO_CNT: rdata = mode ? count[WORD_W-1:0] : {reached, count[WORD_W-2:0]};
            REG_RUN:    rdata = {{(WORD_W-1){1'b0}}, running};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/cpu_dual_timer.sv
`timescale 1ns/1ps
module cpu_dual_timer
    import cdt_pkg::*;
#(
    parameter int STEP_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              user_mode,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * WORD_W;
    localparam logic [CNT_W-1:0] FINE_MASK = ~((CNT_W'(1) << STEP_LSB) - CNT_W'(1));
    localparam logic [CNT_W-1:0] CTR_MAX   = 64'h0000_0000_7FFF_FFFF & FINE_MASK;
    localparam logic [CNT_W-1:0] USER_MAX  = 64'h7FFF_FFFF_FFFF_FFFF & FINE_MASK;
    localparam logic [WORD_W-1:0] LIM_MASK = CTR_MAX[WORD_W-1:0];
    localparam logic [WORD_W-1:0] HI_MASK  = 32'h7FFF_FFFF;

    tmr_state_t       st_d, st_q;
    logic [CNT_W-1:0] term_cnt;
    logic [CNT_W-1:0] step_nxt;
    logic             step_hit;
    logic             bus_wr, bus_rd;

    assign bus_wr = bus_sel && bus_we;
    assign bus_rd = bus_sel && !bus_we;

    always_comb begin
        if (st_q.mode)              term_cnt = USER_MAX;
        else if (st_q.limit == '0)  term_cnt = CTR_MAX;
        else                        term_cnt = {{WORD_W{1'b0}}, st_q.limit};
    end

    cdt_step_adder #(.STEP_LSB(STEP_LSB), .CNT_W(CNT_W)) u_step (
        .cur_cnt (st_q.count),
        .term_cnt(term_cnt),
        .nxt_cnt (step_nxt),
        .hit     (step_hit)
    );

    always_comb begin
        st_d = st_q;
        if (user_mode != st_q.mode) begin
            st_d.mode  = user_mode;
            st_d.count = '0;
            if (user_mode) begin
                st_d.irq     = 1'b0;
                st_d.running = 1'b0;
            end else begin
                st_d.running = 1'b1;
            end
        end else begin
            if (bus_rd && !st_q.mode && bus_addr == REG_HI_LIM) begin
                st_d.reached = 1'b0;
                st_d.irq     = 1'b0;
            end
            if (tick && st_q.running) begin
                st_d.count = step_nxt;
                if (step_hit) begin
                    st_d.reached = 1'b1;
                    if (!st_q.mode) st_d.irq = 1'b1;
                end
            end
            if (bus_wr) begin
                if (st_q.mode) begin
                    case (bus_addr)
                        REG_HI_LIM: begin
                            st_d.count[CNT_W-1:WORD_W] = bus_wdata & HI_MASK;
                            st_d.reached = 1'b0;
                        end
                        REG_LO_CNT: begin
                            st_d.count[WORD_W-1:0] = bus_wdata & FINE_MASK[WORD_W-1:0];
                            st_d.reached = 1'b0;
                        end
                        REG_RUN: st_d.running = bus_wdata[0];
                        default: ;
                    endcase
                end else begin
                    case (bus_addr)
                        REG_HI_LIM: begin
                            st_d.limit = bus_wdata & LIM_MASK;
                            st_d.count = '0;
                            st_d.irq   = 1'b0;
                        end
                        REG_LIM_KEEP: st_d.limit = bus_wdata & LIM_MASK;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.running <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    cdt_rd_mux u_rd (
        .mode   (st_q.mode),
        .addr   (bus_addr),
        .count  (st_q.count),
        .limit  (st_q.limit),
        .reached(st_q.reached),
        .running(st_q.running),
        .rdata  (bus_rdata)
    );

    assign irq = st_q.irq;

    assert_user_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode |-> !irq);
    assert_enter_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mode) |-> (!st_q.running && !irq && st_q.count == '0));
    assert_leave_user_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.mode) |-> (st_q.running && st_q.count == '0));
    assert_ctr_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode |-> st_q.running);
    assert_hi_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.count[CNT_W-1]);
    assert_fine_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_LO_CNT) |-> (bus_rdata[STEP_LSB-1:0] == '0));
    assert_stopped_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode && !st_q.running && !bus_wr && user_mode == st_q.mode)
        |=> $stable(st_q.count));
endmodule

// File: tb/cpu_dual_timer_bench.sv
`timescale 1ns/1ps
module cpu_dual_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        user_mode = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam int STEP = 512;

    always #10 clk = ~clk;

    cpu_dual_timer u_cpu_dual_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 chk(tick_tag(tag), bus_rdata, exp);
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    function automatic string tick_tag(input string t);
        return t;
    endfunction

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(posedge clk); #1; tick = 1'b0;
        end
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk); user_mode = m;
        @(posedge clk); #1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(2'd3, "R1 running", 32'd1);
        rd(2'd1, "R1 count", 32'd0);
        rd(2'd0, "R1 limit", 32'd0);

        // R2 R3 R4 limit sweep
        for (int k = 1; k <= 6; k++) begin
            wr(2'd0, k * STEP);
            if (k > 1) ticks(k - 1);
            chk("R2 pre-limit irq", {31'd0, irq}, 32'd0);
            rd(2'd1, "R2 pre-limit count", (k - 1) * STEP);
            ticks(1);
            chk("R2 limit irq", {31'd0, irq}, 32'd1);
            rd(2'd1, "R3 reached word", 32'h8000_0000);
            rd(2'd0, "R3 limit read", k * STEP);
            chk("R3 ack irq", {31'd0, irq}, 32'd0);
            rd(2'd1, "R3 reached cleared", 32'd0);
        end

        // R4 mask and no-reset limit
        wr(2'd0, 32'h0000_05FF);
        rd(2'd0, "R4 masked limit", 32'h0000_0400);
        wr(2'd0, 8 * STEP);
        ticks(3);
        wr(2'd2, 10 * STEP);
        rd(2'd1, "R4 keep count", 3 * STEP);
        rd(2'd2, "R11 word2 read", 32'd0);
        ticks(6);
        chk("R4 new limit not yet", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R4 new limit hit", {31'd0, irq}, 32'd1);
        rd(2'd0, "R4 limit kept", 10 * STEP);

        // R5 status write ignored in counter mode
        wr(2'd3, 32'd0);
        ticks(2);
        rd(2'd3, "R5 running", 32'd1);
        rd(2'd1, "R5 count advanced", 2 * STEP);

        // R6 enter user mode with irq pending
        ticks(8);
        chk("R6 irq before", {31'd0, irq}, 32'd1);
        set_mode(1'b1);
        chk("R6 irq dropped", {31'd0, irq}, 32'd0);
        rd(2'd3, "R6 stopped", 32'd0);
        rd(2'd1, "R6 count cleared", 32'd0);
        rd(2'd0, "R6 reached kept", 32'h8000_0000);
        ticks(3);
        rd(2'd1, "R8 stopped count", 32'd0);

        // R7 loads
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, "R7 hi masked", 32'h7FFF_FFFF);
        wr(2'd1, 32'h1234_5FFF);
        rd(2'd1, "R7 lo masked", 32'h1234_5E00);

        // R8 start/stop
        wr(2'd3, 32'd1);
        rd(2'd3, "R8 started", 32'd1);
        ticks(4);
        rd(2'd1, "R8 lo advanced", 32'h1234_5E00 + 4 * STEP);
        rd(2'd0, "R8 hi steady", 32'h7FFF_FFFF);
        wr(2'd3, 32'd0);
        ticks(3);
        rd(2'd1, "R8 held", 32'h1234_5E00 + 4 * STEP);
        wr(2'd3, 32'd1);

        // R7 R8 carry sweep
        for (int i = 0; i < 6; i++) begin
            logic [63:0] exp64;
            exp64 = {32'(i), 32'hFFFF_F800} + 64'(STEP * (i + 2));
            wr(2'd0, i);
            wr(2'd1, 32'hFFFF_F800);
            ticks(i + 2);
            rd(2'd1, "R8 sweep lo", exp64[31:0]);
            rd(2'd0, "R7 sweep hi", exp64[63:32]);
        end

        // R9 top of user count
        wr(2'd0, 32'h7FFF_FFFF);
        wr(2'd1, 32'hFFFF_FC00);
        ticks(1);
        chk("R9 irq low", {31'd0, irq}, 32'd0);
        rd(2'd0, "R9 reached wrap", 32'h8000_0000);
        rd(2'd1, "R9 lo wrap", 32'd0);
        wr(2'd1, 32'd0);
        rd(2'd0, "R7 write clears reached", 32'd0);
        rd(2'd2, "R11 word2 user", 32'd0);

        // R10 back to counter mode
        set_mode(1'b0);
        rd(2'd3, "R10 running", 32'd1);
        rd(2'd1, "R10 count cleared", 32'd0);
        rd(2'd0, "R10 limit retained", 10 * STEP);
        ticks(9);
        chk("R10 not yet", {31'd0, irq}, 32'd0);
        ticks(1);
        chk("R10 limit reused", {31'd0, irq}, 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule